// File: doc/BRIEF.md
# Receive Destination Address Gate

This block sits in a receive path between the stage that assembles bytes from the line and the stage that writes bytes into receive buffers. It checks the destination address at the head of each frame and decides whether the frame is addressed to this station. The address can match the station's own unicast address, the all-ones broadcast address, or a group address when group reception is enabled. Until that decision is made, no byte of the frame leaves the block: the leading address bytes wait in a small queue and are released in order only once the frame is accepted.

An external address lookup can veto a frame through a reject input, but only up to the cycle that carries the last address byte. Frames that are rejected, too short or unmatched produce a single discard strobe and never reach the buffer writer, so they take no buffer space. If a collision is signalled while an accepted frame is still arriving, the block stops forwarding and raises a rewind strobe. The writer then moves its pointer back so that the same buffers are reused.

Top module: `rx_addr_gate`

## Requirements
- R1: A frame whose first six bytes equal `station_addr` is accepted. Byte i of the address is `station_addr[8*i+7:8*i]`, and byte 0 is received first.
- R2: A frame whose six address bytes are all 8'hFF is accepted whether or not `group_en` is set.
- R3: A frame whose first byte has bit 0 set (group address, not broadcast) is accepted only when `group_en` is 1. Any other address that does not match is discarded.
- R4: No byte appears on `out_valid` before `frame_accept`. The first output byte follows one cycle after `frame_accept`. Bytes come out in received order, one per cycle, with `out_eof` set only on the frame's last byte.
- R5: If `ext_reject` is high in any cycle from the start-strobe cycle up to the cycle of the sixth byte, the frame is discarded. If it is high in a later cycle, it has no effect.
- R6: `frame_accept` or `frame_discard` is high for one cycle, in the cycle after the sixth byte is captured.
- R7: A frame that ends (`in_eof`) before its sixth byte is discarded in the cycle after its last byte, and produces no output.
- R8: A collision in the address phase discards the frame in the next cycle. No output follows.
- R9: A collision after acceptance, before the frame's last byte, raises `buf_rewind` for one cycle in the next cycle. Output stops at once, and later bytes are ignored until the next start strobe.
- R10: At most one of `frame_accept`, `frame_discard` and `buf_rewind` is high in any cycle. A discarded frame never produces output.
- R11: After reset, all outputs are low.
- R12: A collision after an accepted frame's last byte has been received has no effect: the whole frame is still forwarded and no rewind occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| station_addr | input | ADDR_BYTES*DATA_W | Own unicast address, byte 0 in the low bits |
| group_en | input | 1 | Accept group addresses |
| ext_reject | input | 1 | Veto from external address lookup |
| collision | input | 1 | Collision seen on the line |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | DATA_W | Forwarded byte |
| out_eof | output | 1 | Last forwarded byte of frame |
| frame_accept | output | 1 | One-cycle accept strobe |
| frame_discard | output | 1 | One-cycle discard strobe |
| buf_rewind | output | 1 | One-cycle buffer pointer rewind strobe |

## Verification
The bench targets the boundaries of the address window. These include a reject in the sixth-byte cycle versus the seventh, a collision on byte five versus byte six, a frame that ends exactly on the sixth byte, and a collision in the first idle cycle after an accepted frame. A gate that leaks bytes early would show output before the accept strobe. An off-by-one window would accept a vetoed frame or discard a late-vetoed one. A gate that ignores collision ordering would lose the rewind, or rewind a frame that had already completed. Random frames mix all address kinds, with the group enable toggled, and compare every forwarded byte, the end flag and the cycle of each strobe against a reference model.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_PASS = 2'd2,
    S_DROP = 2'd3
  } gate_state_t;
endpackage

// File: rtl/rx_gate_fifo.sv
module rx_gate_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         rvalid,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign do_push = push && !flush;
  assign do_pop  = pop && !flush && !empty;

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= do_pop;
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_gate_match.sv
module rx_gate_match #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         first,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DATA_W-1:0]            data,
  input  logic [ADDR_BYTES*DATA_W-1:0] station,
  output logic                         ind_hit,
  output logic                         bc_hit,
  output logic                         mc_hit
);
  logic ind_acc, bc_acc, mc_q;
  logic [DATA_W-1:0] own_byte;

  assign own_byte = station[idx*DATA_W +: DATA_W];

  // hits include the byte currently presented
  always_comb begin
    ind_hit = (first ? 1'b1 : ind_acc) && (data == own_byte);
    bc_hit  = (first ? 1'b1 : bc_acc) && (&data);
    mc_hit  = first ? data[0] : mc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_acc <= 1'b0;
      bc_acc  <= 1'b0;
      mc_q    <= 1'b0;
    end else if (en) begin
      ind_acc <= ind_hit;
      bc_acc  <= bc_hit;
      mc_q    <= mc_hit;
    end
  end
endmodule

// File: rtl/rx_addr_gate.sv
module rx_addr_gate
  import rx_gate_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [DATA_W-1:0]            in_data,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic [ADDR_BYTES*DATA_W-1:0] station_addr,
  input  logic                         group_en,
  input  logic                         ext_reject,
  input  logic                         collision,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            out_data,
  output logic                         out_eof,
  output logic                         frame_accept,
  output logic                         frame_discard,
  output logic                         buf_rewind
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int DEPTH = 1 << $clog2(ADDR_BYTES + 2);
  localparam int ENT_W = DATA_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  gate_state_t state, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, byte_idx;
  logic rej_q, rej_d, rej_now;
  logic pass_open, open_d;
  logic acc_d, disc_d, rew_d;
  logic starting, in_addr, frame_byte, last_addr, hit;
  logic push, flush, pop;
  logic ind_hit, bc_hit, mc_hit;
  logic [ENT_W-1:0] fifo_rdata;
  logic fifo_rvalid, fifo_empty;

  assign starting   = (state == S_IDLE) && in_valid && in_sof && !pass_open;
  assign in_addr    = starting || (state == S_ADDR);
  assign byte_idx   = starting ? '0 : idx_q;
  assign frame_byte = in_addr && in_valid && !collision;
  assign last_addr  = (byte_idx == LAST_IDX);
  assign rej_now    = (starting ? 1'b0 : rej_q) | ext_reject;
  assign hit        = ind_hit | bc_hit | (mc_hit & group_en);
  assign pop        = pass_open && !fifo_empty;

  rx_gate_match #(
    .DATA_W     (DATA_W),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_match (
    .clk     (clk),
    .rst     (rst),
    .en      (frame_byte),
    .first   (starting),
    .idx     (byte_idx),
    .data    (in_data),
    .station (station_addr),
    .ind_hit (ind_hit),
    .bc_hit  (bc_hit),
    .mc_hit  (mc_hit)
  );

  rx_gate_fifo #(
    .W     (ENT_W),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .push   (push),
    .wdata  ({in_eof, in_data}),
    .pop    (pop),
    .rdata  (fifo_rdata),
    .rvalid (fifo_rvalid),
    .empty  (fifo_empty)
  );

  always_comb begin
    state_d = state;
    idx_d   = idx_q;
    rej_d   = rej_q;
    open_d  = pass_open;
    push    = 1'b0;
    flush   = 1'b0;
    acc_d   = 1'b0;
    disc_d  = 1'b0;
    rew_d   = 1'b0;
    if (fifo_rvalid && fifo_rdata[DATA_W]) open_d = 1'b0;
    case (state)
      S_IDLE, S_ADDR: begin
        if (in_addr) begin
          rej_d = rej_now;
          if (collision) begin
            disc_d  = 1'b1;
            flush   = 1'b1;
            state_d = S_IDLE;
          end else if (in_valid) begin
            push = 1'b1;
            if (last_addr) begin
              if (hit && !rej_now) begin
                acc_d   = 1'b1;
                open_d  = 1'b1;
                state_d = in_eof ? S_IDLE : S_PASS;
              end else begin
                disc_d  = 1'b1;
                flush   = 1'b1;
                state_d = in_eof ? S_IDLE : S_DROP;
              end
            end else if (in_eof) begin
              disc_d  = 1'b1;
              flush   = 1'b1;
              state_d = S_IDLE;
            end else begin
              idx_d   = IDX_W'(byte_idx + 1'b1);
              state_d = S_ADDR;
            end
          end
        end
      end
      S_PASS: begin
        if (collision) begin
          rew_d   = 1'b1;
          flush   = 1'b1;
          open_d  = 1'b0;
          state_d = S_IDLE;
        end else if (in_valid) begin
          push = 1'b1;
          if (in_eof) state_d = S_IDLE;
        end
      end
      S_DROP: begin
        if (collision || (in_valid && in_eof)) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      idx_q         <= '0;
      rej_q         <= 1'b0;
      pass_open     <= 1'b0;
      frame_accept  <= 1'b0;
      frame_discard <= 1'b0;
      buf_rewind    <= 1'b0;
    end else begin
      state         <= state_d;
      idx_q         <= idx_d;
      rej_q         <= rej_d;
      pass_open     <= open_d;
      frame_accept  <= acc_d;
      frame_discard <= disc_d;
      buf_rewind    <= rew_d;
    end
  end

  assign out_valid = fifo_rvalid;
  assign out_data  = fifo_rvalid ? fifo_rdata[DATA_W-1:0] : '0;
  assign out_eof   = fifo_rvalid && fifo_rdata[DATA_W];
endmodule

// File: rtl/rx_addr_gate_chk.sv
module rx_addr_gate_chk (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_eof,
  input logic frame_accept,
  input logic frame_discard,
  input logic buf_rewind
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else if (frame_accept) open_q <= 1'b1;
    else if (buf_rewind || (out_valid && out_eof)) open_q <= 1'b0;
  end

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_accept, frame_discard, buf_rewind}));

  a_r4_no_early_byte: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> open_q);

  a_r4_release_after_accept: assert property (@(posedge clk) disable iff (rst)
    frame_accept |=> (out_valid || buf_rewind));

  a_r4_eof_closes: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eof) |=> !out_valid);

  a_r9_rewind_in_open_frame: assert property (@(posedge clk) disable iff (rst)
    buf_rewind |-> open_q);

  a_r10_discard_silent: assert property (@(posedge clk) disable iff (rst)
    frame_discard |=> !out_valid);
endmodule

bind rx_addr_gate rx_addr_gate_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .out_valid     (out_valid),
  .out_eof       (out_eof),
  .frame_accept  (frame_accept),
  .frame_discard (frame_discard),
  .buf_rewind    (buf_rewind)
);

// File: tb/rx_addr_gate_bench.sv
module rx_addr_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic [47:0] station_addr;
  logic group_en = 1'b0, ext_reject = 1'b0, collision = 1'b0;
  logic out_valid, out_eof, frame_accept, frame_discard, buf_rewind;
  logic [7:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_gate u_rx_addr_gate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .station_addr(station_addr),
    .group_en(group_en), .ext_reject(ext_reject), .collision(collision),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .frame_accept(frame_accept), .frame_discard(frame_discard),
    .buf_rewind(buf_rewind)
  );

  int checks = 0, fails = 0, cyc = 0;
  int n_acc, n_disc, n_rew, got_n, dec_cyc, rew_cyc, first_out_cyc;
  logic [7:0] got [64];
  logic got_eof [64];
  logic [7:0] fr [32];
  int cap [33];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (got_n == 0) first_out_cyc = cyc;
        if (got_n < 64) begin
          got[got_n] = out_data;
          got_eof[got_n] = out_eof;
        end
        got_n++;
      end
      if (frame_accept)  begin n_acc++;  dec_cyc = cyc; end
      if (frame_discard) begin n_disc++; dec_cyc = cyc; end
      if (buf_rewind)    begin n_rew++;  rew_cyc = cyc; end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] own_byte(input int i);
    return station_addr[8*i +: 8];
  endfunction

  // kind: 0 own, 1 broadcast, 2 group, 3 foreign unicast
  task automatic send_frame(input int len, input int kind, input bit gen,
                            input int rej_at, input int col_at);
    int e_acc, e_disc, e_rew, e_n, key;
    bit coll, matched;
    string req;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < 6 && i < len; i++) begin
      case (kind)
        0: fr[i] = own_byte(i);
        1: fr[i] = 8'hFF;
        default: ;
      endcase
    end
    if (kind == 2) begin
      fr[0] = fr[0] | 8'h01;
      if (len > 1) fr[1] = 8'h5E;
    end
    if (kind == 3) begin
      fr[0] = own_byte(0);
      if (len > 3) fr[3] = own_byte(3) ^ 8'h40;
      else fr[0] = fr[0] ^ 8'h80;
    end
    group_en = gen;
    n_acc = 0; n_disc = 0; n_rew = 0; got_n = 0;
    dec_cyc = -1; rew_cyc = -1; first_out_cyc = -1;
    // reference model
    coll    = (col_at >= 0) && (col_at < len);
    matched = (kind == 0) || (kind == 1) || (kind == 2 && gen);
    e_acc = 0; e_disc = 0; e_rew = 0; e_n = 0;
    req = (kind == 0) ? "R1" : (kind == 1) ? "R2" : "R3";
    if (coll && col_at < 6) begin e_disc = 1; key = col_at; req = "R8"; end
    else if (len < 6) begin e_disc = 1; key = len - 1; req = "R7"; end
    else begin
      key = 5;
      if (rej_at >= 0 && rej_at < 6) begin e_disc = 1; req = "R5"; end
      else if (!matched) e_disc = 1;
      else begin
        e_acc = 1;
        if (rej_at >= 6) req = "R5";
        if (coll) begin e_rew = 1; e_n = col_at - 6; req = "R9"; end
        else begin
          e_n = len;
          if (col_at == len) req = "R12";
        end
      end
    end
    // drive
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = fr[i];
      in_sof = (i == 0); in_eof = (i == len - 1);
      ext_reject = (i == rej_at);
      collision  = (i == col_at);
      @(negedge clk);
      cap[i] = cyc;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; ext_reject = 1'b0;
    collision = (col_at == len);
    @(negedge clk);
    collision = 1'b0;
    repeat (14) @(negedge clk);
    // compare
    check(req, "accept strobes", n_acc, e_acc);
    check(req, "discard strobes", n_disc, e_disc);
    check(e_rew ? "R9" : req, "rewind strobes", n_rew, e_rew);
    check("R4", "bytes forwarded", got_n, e_n);
    if (got_n == e_n) begin
      int bad = 0, eofs = 0;
      for (int i = 0; i < e_n; i++) begin
        if (got[i] != fr[i]) bad++;
        if (got_eof[i]) eofs++;
      end
      check("R4", "mismatched bytes", bad, 0);
      check("R4", "end flags", eofs, (e_acc && !e_rew) ? 1 : 0);
      if (e_n > 0 && !e_rew) check("R4", "end flag on last", int'(got_eof[e_n-1]), 1);
    end
    if (e_acc || e_disc) check("R6", "decision cycle", dec_cyc, cap[key]);
    if (e_n > 0) check("R4", "first byte cycle", first_out_cyc, cap[5] + 1);
    if (e_rew) check("R9", "rewind cycle", rew_cyc, cap[col_at]);
    check("R10", "strobe total", n_acc + n_disc + n_rew, e_acc + e_disc + e_rew);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    station_addr = {8'h9A, 8'h77, 8'h31, 8'hC4, 8'h08, 8'h42};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "outputs after reset",
          int'({out_valid, out_eof, frame_accept, frame_discard, buf_rewind, out_data}), 0);
    send_frame(12, 0, 1'b0, -1, -1);  // R1 own address
    send_frame(10, 1, 1'b0, -1, -1);  // R2 broadcast, group off
    send_frame(10, 2, 1'b0, -1, -1);  // R3 group off
    send_frame(10, 2, 1'b1, -1, -1);  // R3 group on
    send_frame(9, 3, 1'b1, -1, -1);   // R3 foreign
    send_frame(10, 0, 1'b0, 5, -1);   // R5 last window cycle
    send_frame(10, 0, 1'b0, 6, -1);   // R5 late, ignored
    send_frame(10, 0, 1'b0, 0, -1);   // R5 at start strobe
    send_frame(4, 0, 1'b0, -1, -1);   // R7 short
    send_frame(6, 0, 1'b0, -1, -1);   // R4 exactly six bytes
    send_frame(10, 0, 1'b0, -1, 3);   // R8
    send_frame(10, 0, 1'b0, -1, 5);   // R8 boundary
    send_frame(10, 0, 1'b0, -1, 6);   // R9 boundary
    send_frame(14, 1, 1'b0, -1, 10);  // R9 mid frame
    send_frame(9, 0, 1'b0, -1, 9);    // R12 collision after end
    for (int n = 0; n < 60; n++) begin
      int len, kind, rj, cl;
      len  = ($urandom % 4 == 0) ? 1 + int'($urandom % 6) : 6 + int'($urandom % 15);
      kind = int'($urandom % 4);
      rj   = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
      cl   = ($urandom % 5 == 0) ? int'($urandom % (len + 1)) : -1;
      send_frame(len, kind, 1'($urandom), rj, cl);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule